// File: doc/BRIEF.md
# Dual-Length Serial Load Register with Status Readback

This block receives configuration for a sixteen-channel LED sink driver over a three-wire serial link plus a mode select. In grayscale mode the receive path is 192 bits long and a latch pulse copies it into the grayscale register (twelve bits per channel). In correction mode the path is 96 bits long and a latch pulse copies it into the dot-correction register (six bits per channel). The serial output always shows the last bit of the active path, so several blocks can be wired output-to-input in a chain.

After a grayscale latch, the shift register is refilled with a status packet. The packet holds the per-channel open-LED flags, the over-temperature flag and a copy of the correction register. The host clocks it out while it shifts in the next frame. The status sources are plain inputs from analog circuitry. All four pins are sampled by a fast system clock through two-flop synchronizers. Every pin action takes effect on the third system clock edge after the pin changes, so each pin level must be held for at least four system clocks.

Top module: `ldrv_serial_port`

## Requirements
- R1: After synchronous reset, the serial output, the grayscale register, the correction register and the whole shift register are all zero.
- R2: In grayscale mode (mode pin low), each shift-clock rising edge moves the 192-bit path one place toward bit 191, with serial in entering bit 0. The serial output is bit 191, so a bit reappears at the serial output after 192 further shift edges.
- R3: A latch rising edge in grayscale mode copies all 192 shift bits into the grayscale register. The first bit shifted lands in bit 191, and channel n occupies bits 12n+11..12n. The correction register is unchanged. The mode pin must stay steady while the latch is high.
- R4: In correction mode (mode pin high), only shift bits 95..0 form the path, the serial output is bit 95, and bits 191..96 hold their value.
- R5: A latch rising edge in correction mode copies shift bits 95..0 into the correction register, with channel n at bits 6n+5..6n. The grayscale register is unchanged.
- R6: A latch falling edge in grayscale mode replaces the shift register with the status packet: bit n (n < 16) is the open-LED flag of channel n, bit 16 is the over-temperature flag, and bits 119..24 are the correction register. The serial output shows packet bit 191 at once, and each later shift edge presents the next lower bit.
- R7: The open-LED and over-temperature flags in the packet are the values present at the latch falling edge, not at the rising edge.
- R8: Packet bits 23..17 and 191..120 are zero.
- R9: A latch falling edge in correction mode leaves the shift contents unchanged, so the earlier contents still leave through the serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk_pin | input | 1 | Serial shift clock, acts on its rising edge |
| sdin_pin | input | 1 | Serial data in, MSB first |
| lat_pin | input | 1 | Latch; rise transfers, fall loads status in grayscale mode |
| mode_pin | input | 1 | 0 = grayscale (192 bits), 1 = correction (96 bits) |
| lod_flags | input | 16 | Per-channel open-LED flags |
| tef_flag | input | 1 | Over-temperature flag |
| sdo | output | 1 | Serial out, last bit of the active path |
| gs_data | output | 192 | Grayscale register, 12 bits per channel |
| dc_data | output | 96 | Correction register, 6 bits per channel |

## Verification
A shift register that has slipped by one bit, or that uses the wrong length, appears at the serial output as a misplaced bit stream. This shows on the first bit of a readback, or after 96 or 192 shift edges in a chain test. A status load in the wrong mode or at the wrong latch edge changes the first word read back after the latch. It also shows as stale or wrong flags in bits 16..0 of that word. A wrong transfer shows in the parallel registers on the fourth system clock after the latch pin rises. The register that should not change is compared at the same point.

// File: rtl/ldrv_ser_pkg.sv
// Shared definitions for the serial load port.
// Assumes: mode pin low selects grayscale, high selects correction.
package ldrv_ser_pkg;
    typedef enum logic {
        MODE_GRAY = 1'b0,
        MODE_CORR = 1'b1
    } ser_mode_e;
endpackage

// File: rtl/pin_sync.sv
// Two-flop synchronizer for a bundle of asynchronous pins.
// Assumes: each pin is held for several system clocks, so per-bit skew between
// the pins of the bundle is harmless.
module pin_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] lvl
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Purpose: two flops in series per pin to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign lvl = sync_q;
endmodule

// File: rtl/ser_shift.sv
// Shift register with a mode-selected length and a status-packet parallel load.
// Assumes: shift_en and load_stat are single-cycle strobes; a status load wins
// over a shift in the same cycle.
module ser_shift #(
    parameter int CH           = 16,
    parameter int GSW          = 12,
    parameter int DCW          = 6,
    parameter int STAT_DC_BASE = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_corr,
    input  logic                shift_en,
    input  logic                sdin,
    input  logic                load_stat,
    input  logic [CH-1:0]       lod_in,
    input  logic                tef_in,
    input  logic [CH*DCW-1:0]   dc_mirror,
    output logic [CH*GSW-1:0]   sr_q,
    output logic                sdo
);
    localparam int GS_LEN  = CH * GSW;
    localparam int DC_LEN  = CH * DCW;
    localparam int STAT_HI = STAT_DC_BASE + DC_LEN;

    logic [GS_LEN-1:0] stat_word;

    // Purpose: assemble the status packet from flags and correction copy.
    always_comb begin
        stat_word = '0;
        stat_word[CH-1:0] = lod_in;
        stat_word[CH] = tef_in;
        stat_word[STAT_DC_BASE +: DC_LEN] = dc_mirror;
    end

    // Purpose: status load, or shift over the length picked by the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_stat) begin
            sr_q <= stat_word;
        end else if (shift_en) begin
            if (mode_corr) begin
                sr_q[DC_LEN-1:0] <= {sr_q[DC_LEN-2:0], sdin};
            end else begin
                sr_q <= {sr_q[GS_LEN-2:0], sdin};
            end
        end
    end

    assign sdo = mode_corr ? sr_q[DC_LEN-1] : sr_q[GS_LEN-1];

    p_stat_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_stat |=> (sr_q[CH-1:0] == $past(lod_in)) && (sr_q[CH] == $past(tef_in)));

    p_stat_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_stat |=> (sr_q[GS_LEN-1:STAT_HI] == '0) && (sr_q[STAT_DC_BASE-1:CH+1] == '0));

    p_corr_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_corr && !load_stat) |=> $stable(sr_q[GS_LEN-1:DC_LEN]));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_stat && !shift_en) |=> $stable(sr_q));
endmodule

// File: rtl/ser_hold_regs.sv
// Parallel grayscale and correction registers loaded from the shift register.
// Assumes: lat_rise is a single-cycle strobe and mode_corr is steady around it.
module ser_hold_regs #(
    parameter int CH  = 16,
    parameter int GSW = 12,
    parameter int DCW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lat_rise,
    input  logic                 mode_corr,
    input  logic [CH*GSW-1:0]    sr_q,
    output logic [CH*GSW-1:0]    gs_q,
    output logic [CH*DCW-1:0]    dc_q
);
    localparam int DC_LEN = CH * DCW;

    // Purpose: copy the shift contents into the register chosen by the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gs_q <= '0;
            dc_q <= '0;
        end else if (lat_rise) begin
            if (mode_corr) begin
                dc_q <= sr_q[DC_LEN-1:0];
            end else begin
                gs_q <= sr_q;
            end
        end
    end

    p_gs_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_rise && mode_corr) |=> $stable(gs_q));

    p_dc_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_rise && !mode_corr) |=> $stable(dc_q));
endmodule

// File: rtl/ldrv_serial_port.sv
// Top of the serial load port: pin synchronizers, edge detection, the
// dual-length shift register and the parallel registers.
// Assumes: pins are asynchronous to clk, each level is held at least four
// system clocks, and the mode pin changes only while the latch pin is low.
module ldrv_serial_port
    import ldrv_ser_pkg::*;
#(
    parameter int CH           = 16,
    parameter int GSW          = 12,
    parameter int DCW          = 6,
    parameter int STAT_DC_BASE = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_pin,
    input  logic                 sdin_pin,
    input  logic                 lat_pin,
    input  logic                 mode_pin,
    input  logic [CH-1:0]        lod_flags,
    input  logic                 tef_flag,
    output logic                 sdo,
    output logic [CH*GSW-1:0]    gs_data,
    output logic [CH*DCW-1:0]    dc_data
);
    localparam int GS_LEN = CH * GSW;
    localparam int DC_LEN = CH * DCW;

    logic [3:0]        pins_lvl;
    logic              sclk_lvl;
    logic              sdin_lvl;
    logic              lat_lvl;
    ser_mode_e         mode_sel;
    logic              mode_corr;
    logic              sclk_prev;
    logic              lat_prev;
    logic              sclk_rise;
    logic              lat_rise;
    logic              lat_fall;
    logic              load_stat;
    logic [GS_LEN-1:0] sr_q;

    pin_sync #(.W(4)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({mode_pin, lat_pin, sdin_pin, sclk_pin}),
        .lvl     (pins_lvl)
    );

    assign sclk_lvl  = pins_lvl[0];
    assign sdin_lvl  = pins_lvl[1];
    assign lat_lvl   = pins_lvl[2];
    assign mode_sel  = ser_mode_e'(pins_lvl[3]);
    assign mode_corr = (mode_sel == MODE_CORR);

    // Purpose: remember the previous synchronized clock and latch levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            lat_prev  <= 1'b0;
        end else begin
            sclk_prev <= sclk_lvl;
            lat_prev  <= lat_lvl;
        end
    end

    assign sclk_rise = sclk_lvl & ~sclk_prev;
    assign lat_rise  = lat_lvl & ~lat_prev;
    assign lat_fall  = ~lat_lvl & lat_prev;
    assign load_stat = lat_fall & ~mode_corr;

    ser_shift #(
        .CH(CH), .GSW(GSW), .DCW(DCW), .STAT_DC_BASE(STAT_DC_BASE)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_corr (mode_corr),
        .shift_en  (sclk_rise),
        .sdin      (sdin_lvl),
        .load_stat (load_stat),
        .lod_in    (lod_flags),
        .tef_in    (tef_flag),
        .dc_mirror (dc_data),
        .sr_q      (sr_q),
        .sdo       (sdo)
    );

    ser_hold_regs #(.CH(CH), .GSW(GSW), .DCW(DCW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_rise  (lat_rise),
        .mode_corr (mode_corr),
        .sr_q      (sr_q),
        .gs_q      (gs_data),
        .dc_q      (dc_data)
    );

    p_mode_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lat_lvl |-> $stable(mode_sel));

    p_corr_no_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_fall && mode_corr) |=> $stable(gs_data) && $stable(dc_data));

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (sr_q == '0) && (gs_data == '0) && (dc_data == '0));
endmodule

// File: tb/tb_ldrv_serial_port.sv
module tb_ldrv_serial_port;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    // {mode, tef, lod[15:0], seed[31:0]}
    localparam logic [49:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 16'h0000, 32'h1234_5678},
        {1'b1, 1'b0, 16'h0000, 32'h0BAD_F00D},
        {1'b0, 1'b1, 16'hA5C3, 32'hDEAD_BEEF},
        {1'b1, 1'b0, 16'h0000, 32'h55AA_1F2E},
        {1'b0, 1'b1, 16'hFFFF, 32'h0000_0001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdin = 1'b0, lat = 1'b0, mode = 1'b0;
    logic [15:0] lod = '0;
    logic tef = 1'b0;
    logic sdo;
    logic [191:0] gs_data;
    logic [95:0]  dc_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldrv_serial_port dut (
        .clk(clk), .rst_n(rst_n), .sclk_pin(sclk), .sdin_pin(sdin),
        .lat_pin(lat), .mode_pin(mode), .lod_flags(lod), .tef_flag(tef),
        .sdo(sdo), .gs_data(gs_data), .dc_data(dc_data)
    );

    function automatic logic [191:0] gen(input logic [31:0] seed);
        logic [31:0] x;
        logic [191:0] r;
        x = seed | 32'h1;
        r = '0;
        for (int i = 0; i < 192; i++) begin
            x = x ^ (x << 13);
            x = x ^ (x >> 17);
            x = x ^ (x << 5);
            r[i] = x[0];
        end
        return r;
    endfunction

    function automatic logic [191:0] stat_pkt(input logic [15:0] l, input logic t,
                                              input logic [95:0] d);
        logic [191:0] s;
        s = '0;
        s[15:0] = l;
        s[16] = t;
        s[24 +: 96] = d;
        return s;
    endfunction

    task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        sdin = b;
        idle(1);
        sclk = 1'b1;
        idle(4);
        sclk = 1'b0;
        idle(4);
    endtask

    // Shift n bits of w, MSB (bit n-1) first, recording sdo before each edge.
    task automatic shift_word(input logic [191:0] w, input int n, output logic [191:0] seen);
        seen = '0;
        for (int i = 0; i < n; i++) begin
            seen[n-1-i] = sdo;
            shift_bit(w[n-1-i]);
        end
    endtask

    task automatic pulse_lat();
        lat = 1'b1;
        idle(5);
        lat = 1'b0;
        idle(5);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [191:0] gs_exp, data, seen, a, b;
        logic [95:0]  dc_exp;
        gs_exp = '0;
        dc_exp = '0;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1: reset state
        check("R1 sdo", {191'b0, sdo}, '0);
        check("R1 gs_data", gs_data, '0);
        check("R1 dc_data", {96'b0, dc_data}, '0);

        // Table of vectors: load, check registers, read status in grayscale
        for (int v = 0; v < NVEC; v++) begin
            mode = VEC[v][49];
            idle(5);
            data = gen(VEC[v][31:0]);
            if (mode) begin
                shift_word(data, 96, seen);
                tef = VEC[v][48];
                lod = VEC[v][47:32];
                pulse_lat();
                dc_exp = data[95:0];
                check("R5 dc load", {96'b0, dc_data}, {96'b0, dc_exp});
                check("R5 gs kept", gs_data, gs_exp);
            end else begin
                shift_word(data, 192, seen);
                tef = VEC[v][48];
                lod = VEC[v][47:32];
                pulse_lat();
                gs_exp = data;
                check("R3 gs load", gs_data, gs_exp);
                check("R3 dc kept", {96'b0, dc_data}, {96'b0, dc_exp});
                // R6/R8: status packet read out MSB first
                shift_word('0, 192, seen);
                check("R6 R8 status", seen, stat_pkt(VEC[v][47:32], VEC[v][48], dc_exp));
            end
        end

        // R2: 192-bit chain delay in grayscale mode
        mode = 1'b0;
        idle(5);
        a = gen(32'hC0FF_EE01);
        b = gen(32'h7777_1234);
        shift_word(a, 192, seen);
        shift_word(b, 192, seen);
        check("R2 chain", seen, a);

        // R4: 96-bit chain delay in correction mode
        mode = 1'b1;
        idle(5);
        a = gen(32'h0F0F_3C3C);
        b = gen(32'h9999_AAAA);
        shift_word(a, 96, seen);
        shift_word(b, 96, seen);
        check("R4 chain", seen, {96'b0, a[95:0]});

        // R9: correction latch does not load status; contents still shift out
        a = gen(32'h2468_ACE0);
        shift_word(a, 96, seen);
        lod = 16'hFFFF;
        tef = 1'b1;
        pulse_lat();
        dc_exp = a[95:0];
        check("R9 dc load", {96'b0, dc_data}, {96'b0, dc_exp});
        shift_word('0, 96, seen);
        check("R9 no status", seen, {96'b0, a[95:0]});

        // R7: flags captured at latch fall, not rise
        mode = 1'b0;
        idle(5);
        a = gen(32'h1357_9BDF);
        shift_word(a, 192, seen);
        lod = 16'h1111;
        tef = 1'b0;
        lat = 1'b1;
        idle(5);
        lod = 16'h8421;
        tef = 1'b1;
        idle(3);
        lat = 1'b0;
        idle(5);
        check("R6 first bit", {191'b0, sdo}, '0);
        shift_word('0, 192, seen);
        check("R7 fall capture", seen, stat_pkt(16'h8421, 1'b1, dc_exp));

        // R1: reset in mid-operation clears everything
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check("R1 gs after reset", gs_data, '0);
        check("R1 dc after reset", {96'b0, dc_data}, '0);
        shift_word('0, 192, seen);
        check("R1 shift cleared", seen, '0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule